// File: doc/BRIEF.md
# Row-Latched Data EEPROM Controller

This block controls a small byte-addressed data memory that is updated one row at a time. A row holds `ROW_BYTES` bytes; the low address bits pick the byte and the upper bits pick the row. The array itself is a plain register array here and has no reset.

Software updates a row in two steps. First it sets the latch bit in the control register and writes bytes into a bank of row latches. Each latch has its own valid flag, and the first latched write fixes the row. Then it sets the program bit. This starts a timed cycle, and when the cycle ends only the flagged bytes are copied into the array. While the latch bit is set, reads of the memory range are refused. At the end of the cycle hardware clears both bits.

Two power handshakes are provided. A wait request is honoured only once any programming cycle in progress has finished. A halt request stops a running cycle at once and marks the affected row as suspect.

Top module: `rowlatch_eeprom_ctrl`

## Requirements
- R1: A memory address splits into byte-in-row (low `log2(ROW_BYTES)` bits, 5 by default) and row (upper bits). After a row is programmed, reads at row*ROW_BYTES+col return the byte written for that column.
- R2: While the latch bit (control bit 0) is 1, memory writes go only to the row latches. Clearing the latch bit by software before programming drops the latched bytes, and the array keeps its old contents.
- R3: Writing control bits 0 and 1 both as 1 while the latch bit is already 1 starts a programming cycle. Busy is then high for exactly `PROG_CYCLES` clock cycles. At its end the latch, program and busy bits all read 0, and the latched bytes are in the array.
- R4: A memory read issued while the latch bit is 1 leaves `rdata_oe_o` low in the result cycle.
- R5: A memory write issued while the latch bit is 0 changes nothing in the array.
- R6: Setting the latch bit from 0 clears all per-byte valid flags. Programming updates only the bytes written since then, and every other byte of the row keeps its value.
- R7: The row of the first latched write is locked. Later latched writes to any other row are ignored.
- R8: A wait request is acknowledged (`wait_ack_o` high) on the cycle after the request if the block is idle. During a programming cycle the acknowledge stays low until the cycle has completed and committed, and rises one cycle after busy falls.
- R9: A halt request during programming takes effect at the next edge. It clears busy and the latch and program bits, raises `halt_ack_o`, sets the suspect flag (control bit 3, `suspect_o`) and reports the row on `suspect_row_o`. No byte is committed. The next completed programming cycle clears the suspect flag.
- R10: Writing the program bit while the latch bit is 0 has no effect: busy stays 0 and the program bit reads 0.
- R11: While busy, control register writes are ignored and memory writes do not reach the latches.
- R12: Reset clears the control register, both acknowledges and `rdata_oe_o`. A reset during programming abandons the cycle, and nothing is committed.
- R13: A read returns its data with `rdata_oe_o` high one cycle after the request. The control register reads as bit0 latch, bit1 program, bit2 busy, bit3 suspect, and the upper bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_req_i | input | 1 | Access to the memory range |
| reg_req_i | input | 1 | Access to the control register |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Memory byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, one cycle after request |
| rdata_oe_o | output | 1 | Read data valid/driven |
| wait_req_i | input | 1 | Wait-mode request |
| halt_req_i | input | 1 | Halt-mode request |
| wait_ack_o | output | 1 | Block is in wait |
| halt_ack_o | output | 1 | Block is halted |
| busy_o | output | 1 | Programming cycle running |
| suspect_o | output | 1 | Last programming was cut short by halt |
| suspect_row_o | output | 3 | Row affected by the halted cycle |

## Verification
The assertions assume that `mem_req_i` and `reg_req_i` are never high together, and that bus requests are issued only while neither power request is active. The bench drives a single access per cycle on the falling edge and holds both power requests low during any bus traffic. It raises the halt request only while a programming cycle is running, and it raises the wait request both with the block idle and with a cycle running.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_WAIT = 2'd1,
    PWR_HALT = 2'd2
  } pwr_e;

  localparam int unsigned CTL_LAT_BIT = 0;
  localparam int unsigned CTL_PGM_BIT = 1;
  localparam int unsigned CTL_BSY_BIT = 2;
  localparam int unsigned CTL_SUS_BIT = 3;
endpackage

// File: rtl/eep_row_latch.sv
module eep_row_latch #(
  parameter int unsigned ROW_BYTES = 32,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ROW_W     = 3,
  parameter int unsigned COL_W     = 5
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             clr_i,
  input  logic                             wr_i,
  input  logic [ROW_W-1:0]                 row_i,
  input  logic [COL_W-1:0]                 col_i,
  input  logic [DATA_W-1:0]                data_i,
  output logic [ROW_BYTES-1:0]             mask_o,
  output logic [ROW_BYTES-1:0][DATA_W-1:0] data_o,
  output logic [ROW_W-1:0]                 row_o,
  output logic                             locked_o
);
  logic             locked_q;
  logic [ROW_W-1:0] row_q;
  logic             accept;

  // first write locks the row, others must match it
  assign accept = wr_i && (!locked_q || (row_i == row_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      row_q    <= '0;
    end else if (clr_i) begin
      locked_q <= 1'b0;
    end else if (accept && !locked_q) begin
      locked_q <= 1'b1;
      row_q    <= row_i;
    end
  end

  for (genvar b = 0; b < ROW_BYTES; b++) begin : g_byte
    logic              hit;
    logic              vld_q;
    logic [DATA_W-1:0] dat_q;

    assign hit = accept && (col_i == COL_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else if (clr_i) begin
        vld_q <= 1'b0;
      end else if (hit) begin
        vld_q <= 1'b1;
        dat_q <= data_i;
      end
    end

    assign mask_o[b] = vld_q;
    assign data_o[b] = dat_q;
  end

  assign row_o    = row_q;
  assign locked_o = locked_q;
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign done_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (abort_i || done_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= LAST;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/eep_pwr_ctl.sv
module eep_pwr_ctl
  import eep_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_req_i,
  input  logic halt_req_i,
  input  logic busy_i,
  output pwr_e state_o,
  output logic abort_o
);
  pwr_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PWR_RUN: begin
        if (halt_req_i)                 state_d = PWR_HALT;
        else if (wait_req_i && !busy_i) state_d = PWR_WAIT;
      end
      PWR_WAIT: begin
        if (halt_req_i)       state_d = PWR_HALT;
        else if (!wait_req_i) state_d = PWR_RUN;
      end
      PWR_HALT: begin
        if (!halt_req_i) state_d = PWR_RUN;
      end
      default: state_d = PWR_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PWR_RUN;
    else         state_q <= state_d;
  end

  // halt cuts a running cycle short
  assign abort_o = halt_req_i && busy_i && (state_q != PWR_HALT);
  assign state_o = state_q;
endmodule

// File: rtl/rowlatch_eeprom_ctrl.sv
module rowlatch_eeprom_ctrl
  import eep_pkg::*;
#(
  parameter int unsigned ROW_BYTES   = 32,
  parameter int unsigned NUM_ROWS    = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PROG_CYCLES = 1000,
  localparam int unsigned COL_W      = $clog2(ROW_BYTES),
  localparam int unsigned ROW_W      = $clog2(NUM_ROWS),
  localparam int unsigned ADDR_W     = ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_req_i,
  input  logic              reg_req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  input  logic              wait_req_i,
  input  logic              halt_req_i,
  output logic              wait_ack_o,
  output logic              halt_ack_o,
  output logic              busy_o,
  output logic              suspect_o,
  output logic [ROW_W-1:0]  suspect_row_o
);
  logic [DATA_W-1:0] mem_q [NUM_ROWS][ROW_BYTES];

  logic             lat_q, pgm_q, sus_q;
  logic [ROW_W-1:0] sus_row_q;
  logic             bus_ok, reg_wr, reg_rd, mem_wr, mem_rd;
  logic             lat_set, prog_start, busy, tdone, commit, abort;
  logic [ROW_W-1:0] a_row;
  logic [COL_W-1:0] a_col;
  pwr_e             pstate;

  logic [ROW_BYTES-1:0]             l_mask;
  logic [ROW_BYTES-1:0][DATA_W-1:0] l_data;
  logic [ROW_W-1:0]                 l_row;
  logic                             l_locked;
  logic [DATA_W-1:0]                ctl_val;

  assign a_row = addr_i[ADDR_W-1:COL_W];
  assign a_col = addr_i[COL_W-1:0];

  assign bus_ok = (pstate == PWR_RUN) && !halt_req_i;
  assign reg_wr = bus_ok && reg_req_i && we_i;
  assign reg_rd = bus_ok && reg_req_i && !we_i;
  assign mem_wr = bus_ok && !reg_req_i && mem_req_i && we_i && lat_q && !busy;
  assign mem_rd = bus_ok && !reg_req_i && mem_req_i && !we_i && !lat_q;

  assign lat_set    = reg_wr && !busy && !lat_q && wdata_i[CTL_LAT_BIT];
  assign prog_start = reg_wr && !busy && lat_q &&
                      wdata_i[CTL_LAT_BIT] && wdata_i[CTL_PGM_BIT];
  assign commit     = tdone && !abort;

  eep_pwr_ctl u_pwr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wait_req_i (wait_req_i),
    .halt_req_i (halt_req_i),
    .busy_i     (busy),
    .state_o    (pstate),
    .abort_o    (abort)
  );

  eep_prog_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (prog_start),
    .abort_i (abort),
    .busy_o  (busy),
    .done_o  (tdone)
  );

  eep_row_latch #(
    .ROW_BYTES (ROW_BYTES),
    .DATA_W    (DATA_W),
    .ROW_W     (ROW_W),
    .COL_W     (COL_W)
  ) u_lat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (lat_set),
    .wr_i     (mem_wr),
    .row_i    (a_row),
    .col_i    (a_col),
    .data_i   (wdata_i),
    .mask_o   (l_mask),
    .data_o   (l_data),
    .row_o    (l_row),
    .locked_o (l_locked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= 1'b0;
      pgm_q <= 1'b0;
    end else if (abort || commit) begin
      lat_q <= 1'b0;
      pgm_q <= 1'b0;
    end else if (reg_wr && !busy) begin
      lat_q <= wdata_i[CTL_LAT_BIT];
      pgm_q <= prog_start;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sus_q     <= 1'b0;
      sus_row_q <= '0;
    end else if (abort) begin
      sus_q     <= 1'b1;
      sus_row_q <= l_row;
    end else if (commit) begin
      sus_q     <= 1'b0;
    end
  end

  // nonvolatile model: no reset on the array
  always_ff @(posedge clk_i) begin
    if (commit && l_locked) begin
      for (int b = 0; b < ROW_BYTES; b++) begin
        if (l_mask[b]) mem_q[l_row][b] <= l_data[b];
      end
    end
  end

  always_comb begin
    ctl_val              = '0;
    ctl_val[CTL_LAT_BIT] = lat_q;
    ctl_val[CTL_PGM_BIT] = pgm_q;
    ctl_val[CTL_BSY_BIT] = busy;
    ctl_val[CTL_SUS_BIT] = sus_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o    <= '0;
      rdata_oe_o <= 1'b0;
    end else if (reg_rd) begin
      rdata_o    <= ctl_val;
      rdata_oe_o <= 1'b1;
    end else if (mem_rd) begin
      rdata_o    <= mem_q[a_row][a_col];
      rdata_oe_o <= 1'b1;
    end else begin
      rdata_o    <= '0;
      rdata_oe_o <= 1'b0;
    end
  end

  assign wait_ack_o    = (pstate == PWR_WAIT);
  assign halt_ack_o    = (pstate == PWR_HALT);
  assign busy_o        = busy;
  assign suspect_o     = sus_q;
  assign suspect_row_o = sus_row_q;
endmodule

// File: rtl/eep_ctrl_chk.sv
module eep_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_ok,
  input logic mem_req_i,
  input logic reg_req_i,
  input logic we_i,
  input logic lat_q,
  input logic pgm_q,
  input logic busy_o,
  input logic rdata_oe_o,
  input logic wait_ack_o,
  input logic halt_ack_o,
  input logic halt_req_i,
  input logic suspect_o
);
  // R4
  rd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_ok && mem_req_i && !reg_req_i && !we_i && lat_q) |=> !rdata_oe_o);

  // R3
  busy_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (lat_q && pgm_q));

  // R3
  end_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (!lat_q && !pgm_q));

  // R8
  wait_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_ack_o |-> !busy_o);

  // R9
  halt_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_req_i && busy_o && !halt_ack_o) |=> (!busy_o && suspect_o && halt_ack_o));

  // R10
  pgm_noeffect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_ok && reg_req_i && we_i && !lat_q && !busy_o) |=> (!busy_o && !pgm_q));
endmodule

bind rowlatch_eeprom_ctrl eep_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_ok     (bus_ok),
  .mem_req_i  (mem_req_i),
  .reg_req_i  (reg_req_i),
  .we_i       (we_i),
  .lat_q      (lat_q),
  .pgm_q      (pgm_q),
  .busy_o     (busy_o),
  .rdata_oe_o (rdata_oe_o),
  .wait_ack_o (wait_ack_o),
  .halt_ack_o (halt_ack_o),
  .halt_req_i (halt_req_i),
  .suspect_o  (suspect_o)
);

// File: tb/rowlatch_eeprom_ctrl_tb.sv
module rowlatch_eeprom_ctrl_tb;
  localparam int RB = 32;
  localparam int NR = 8;
  localparam int PC = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mem_req_i = 1'b0, reg_req_i = 1'b0, we_i = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0;
  logic [7:0] rdata_o;
  logic       rdata_oe_o;
  logic       wait_req_i = 1'b0, halt_req_i = 1'b0;
  logic       wait_ack_o, halt_ack_o, busy_o, suspect_o;
  logic [2:0] suspect_row_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] ref_mem [NR*RB];

  always #10 clk_i = ~clk_i;

  rowlatch_eeprom_ctrl #(.ROW_BYTES(RB), .NUM_ROWS(NR), .DATA_W(8), .PROG_CYCLES(PC)) u_dut (
    .clk_i, .rst_ni, .mem_req_i, .reg_req_i, .we_i, .addr_i, .wdata_i,
    .rdata_o, .rdata_oe_o, .wait_req_i, .halt_req_i, .wait_ack_o, .halt_ack_o,
    .busy_o, .suspect_o, .suspect_row_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl_wr(input logic [7:0] v);
    reg_req_i = 1'b1; we_i = 1'b1; wdata_i = v;
    @(negedge clk_i);
    reg_req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic mem_wr(input int a, input logic [7:0] d);
    mem_req_i = 1'b1; we_i = 1'b1; addr_i = 8'(a); wdata_i = d;
    @(negedge clk_i);
    mem_req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input bit is_reg, input int a, output logic [7:0] d, output logic oe);
    reg_req_i = is_reg; mem_req_i = !is_reg; we_i = 1'b0; addr_i = 8'(a);
    @(negedge clk_i);
    d = rdata_o; oe = rdata_oe_o;
    reg_req_i = 1'b0; mem_req_i = 1'b0;
  endtask

  task automatic ctl_expect(input logic [7:0] exp, input string req);
    logic [7:0] d; logic oe;
    rd(1'b1, 0, d, oe);
    chk(oe && d == exp, req, {oe, d}, {1'b1, exp});
  endtask

  task automatic row_expect(input int r, input string req);
    logic [7:0] d; logic oe;
    for (int c = 0; c < RB; c++) begin
      rd(1'b0, r*RB + c, d, oe);
      chk(oe && d == ref_mem[r*RB+c], req, {oe, d}, {1'b1, ref_mem[r*RB+c]});
    end
  endtask

  task automatic prog_timed(input string req);
    int cnt = 0;
    ctl_wr(8'h03);
    while (busy_o) begin
      cnt++;
      @(negedge clk_i);
    end
    chk(cnt == PC, req, cnt, PC);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d; logic oe;
    repeat (3) @(negedge clk_i);
    // R12: reset state
    chk(rdata_oe_o == 1'b0 && wait_ack_o == 1'b0 && halt_ack_o == 1'b0, "R12 reset outs",
        {rdata_oe_o, wait_ack_o, halt_ack_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    ctl_expect(8'h00, "R12/R13 ctl after reset");

    // R1/R3: program every row fully, then read back everything
    for (int r = 0; r < NR; r++) begin
      ctl_wr(8'h01);
      for (int c = 0; c < RB; c++) begin
        ref_mem[r*RB+c] = 8'((r*RB + c) * 37 + r * 11 + 5);
        mem_wr(r*RB + c, ref_mem[r*RB+c]);
      end
      prog_timed("R3 busy length");
      ctl_expect(8'h00, "R3 bits cleared");
    end
    for (int r = 0; r < NR; r++) row_expect(r, "R1 sweep readback");

    // R5: write with latch clear ignored
    mem_wr(5, 8'hAA);
    rd(1'b0, 5, d, oe);
    chk(oe && d == ref_mem[5], "R5 unlatched write", d, ref_mem[5]);

    // R2/R4: latch, refused read, discard
    ctl_wr(8'h01);
    ctl_expect(8'h01, "R13 latch bit");
    mem_wr(3*RB + 2, 8'h11);
    mem_wr(3*RB + 9, 8'h22);
    rd(1'b0, 3*RB + 2, d, oe);
    chk(oe == 1'b0, "R4 read during latch", oe, 0);
    ctl_wr(8'h00);
    rd(1'b0, 3*RB + 2, d, oe);
    chk(oe && d == ref_mem[3*RB+2], "R2 discard col2", d, ref_mem[3*RB+2]);
    rd(1'b0, 3*RB + 9, d, oe);
    chk(oe && d == ref_mem[3*RB+9], "R2 discard col9", d, ref_mem[3*RB+9]);

    // R6: mask cleared on relatch, only byte 7 changes
    ctl_wr(8'h01);
    mem_wr(3*RB + 7, 8'h5C);
    prog_timed("R6 busy length");
    ref_mem[3*RB+7] = 8'h5C;
    row_expect(3, "R6 masked update");

    // R7: row lock
    ctl_wr(8'h01);
    mem_wr(1*RB + 4, 8'h44);
    mem_wr(2*RB + 4, 8'h99);
    mem_wr(1*RB + 31, 8'h31);
    prog_timed("R7 busy length");
    ref_mem[1*RB+4] = 8'h44;
    ref_mem[1*RB+31] = 8'h31;
    row_expect(1, "R7 locked row");
    row_expect(2, "R7 other row");

    // R10: program bit without latch
    ctl_wr(8'h02);
    chk(busy_o == 1'b0, "R10 busy", busy_o, 0);
    ctl_expect(8'h00, "R10 ctl");

    // R11: writes during busy ignored
    ctl_wr(8'h01);
    mem_wr(5*RB + 0, 8'h12);
    ctl_wr(8'h03);
    ctl_wr(8'h00);
    ctl_expect(8'h07, "R11 ctl during busy");
    mem_wr(5*RB + 1, 8'hEE);
    while (busy_o) @(negedge clk_i);
    ref_mem[5*RB+0] = 8'h12;
    ctl_expect(8'h00, "R11 ctl after");
    row_expect(5, "R11 row");

    // R8: wait when idle
    wait_req_i = 1'b1;
    @(negedge clk_i);
    chk(wait_ack_o == 1'b1, "R8 idle wait ack", wait_ack_o, 1);
    wait_req_i = 1'b0;
    @(negedge clk_i);
    chk(wait_ack_o == 1'b0, "R8 wait release", wait_ack_o, 0);

    // R8: wait deferred behind programming
    ctl_wr(8'h01);
    mem_wr(6*RB + 3, 8'h63);
    ctl_wr(8'h03);
    wait_req_i = 1'b1;
    while (busy_o) begin
      chk(wait_ack_o == 1'b0, "R8 no ack while busy", wait_ack_o, 0);
      @(negedge clk_i);
    end
    chk(wait_ack_o == 1'b0, "R8 ack after busy falls", wait_ack_o, 0);
    @(negedge clk_i);
    chk(wait_ack_o == 1'b1, "R8 deferred ack", wait_ack_o, 1);
    wait_req_i = 1'b0;
    repeat (2) @(negedge clk_i);
    ref_mem[6*RB+3] = 8'h63;
    row_expect(6, "R8 commit before wait");

    // R9: halt aborts
    ctl_wr(8'h01);
    mem_wr(4*RB + 0, 8'hA4);
    ctl_wr(8'h03);
    repeat (3) @(negedge clk_i);
    halt_req_i = 1'b1;
    @(negedge clk_i);
    chk(busy_o == 1'b0 && halt_ack_o == 1'b1, "R9 halt stops", {busy_o, halt_ack_o}, 2'b01);
    chk(suspect_o == 1'b1 && suspect_row_o == 3'd4, "R9 suspect row",
        {suspect_o, suspect_row_o}, {1'b1, 3'd4});
    halt_req_i = 1'b0;
    @(negedge clk_i);
    chk(halt_ack_o == 1'b0, "R9 halt release", halt_ack_o, 0);
    ctl_expect(8'h08, "R9 ctl suspect only");
    row_expect(4, "R9 no commit");
    ctl_wr(8'h01);
    mem_wr(4*RB + 0, 8'hA4);
    prog_timed("R9 reprogram length");
    ref_mem[4*RB+0] = 8'hA4;
    chk(suspect_o == 1'b0, "R9 suspect cleared", suspect_o, 0);
    row_expect(4, "R9 reprogram");

    // R12: reset mid-programming
    ctl_wr(8'h01);
    mem_wr(7*RB + 8, 8'h78);
    ctl_wr(8'h03);
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o == 1'b0, "R12 busy after reset", busy_o, 0);
    ctl_expect(8'h00, "R12 ctl after reset");
    repeat (PC) @(negedge clk_i);
    row_expect(7, "R12 abandoned cycle");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule